// File: doc/BRIEF.md
# XOFF Retransmit Holdoff Timer

This block tells a flow-control transmitter when to repeat an XOFF request while congestion persists. It serves one link-level pause channel and a parameterised number of priority classes. Each channel holds a 16-bit holdoff value counted in quanta. The length of a quantum in clock cycles depends on the selected link speed. When a channel's XOFF has been sent and its congestion level stays high for the whole holdoff interval, the block raises a one-cycle retransmit request on that channel.

The transmitter drives the XOFF level and an XOFF-sent strobe for each channel. Software programs the holdoff values through a simple write port. Address 0 selects the link pause channel, and addresses 1 to NUM_PRI select priority classes 0 to NUM_PRI-1.

There are two resets:
- The power-on reset loads the all-ones value into every holdoff register.
- The active-low configuration reset loads the elaboration-time defaults: one parameter for the pause channel and one 16-bit field per priority class.

Top module: `xoff_holdoff_timer`

## Requirements
- R1: Each channel has its own 16-bit holdoff register. A write with `wr_en` high and `wr_addr` equal to the channel index (0 = pause, k+1 = priority class k) loads `wr_data`. Writes to any address at or above NUM_PRI+1 change no channel.
- R2: With `speed_sel` equal to 2'b00, 2'b01 or 2'b11, one quantum is 8 cycles. The request appears exactly value*8 clock edges after the edge that samples `xoff_sent` with `xoff_active` high.
- R3: With `speed_sel` equal to 2'b10, one quantum is 2 cycles, so the request appears value*2 edges after the sampling edge.
- R4: A request is raised only if `retx_en` for that channel is high in the cycle the interval expires. If it is low, the interval ends silently.
- R5: A stored holdoff value of 0 behaves exactly like a value of 1.
- R6: After the power-on reset (`por_n` low), every holdoff register holds 16'hFFFF.
- R7: After the configuration reset (`cfg_rst_n` low while `por_n` is high), the pause channel holds PAUSE_DEFAULT and priority class k holds bits [16k+15:16k] of PFC_DEFAULTS.
- R8: While `xoff_active` is low, the channel's countdown is cleared and no request is raised. Raising the level again without a new `xoff_sent` produces no request.
- R9: A write during a countdown does not alter that countdown. The new value applies from the next `xoff_sent`.
- R10: `retx_req` is high for one cycle only. No further request follows on that channel until the next `xoff_sent`.
- R11: Channels count independently of one another.
- R12: If `xoff_sent` arrives in the cycle the interval would expire, the reload takes priority and no request is raised for the old interval.
- R13: The quantum length is captured at reload. Changing `speed_sel` during a countdown does not change the running interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| cfg_rst_n | input | 1 | Configuration reset, active low, synchronous |
| speed_sel | input | 2 | Link speed: 2'b10 selects 2-cycle quanta, other codes select 8-cycle quanta |
| wr_en | input | 1 | Holdoff register write strobe |
| wr_addr | input | $clog2(NUM_PRI+1) | Channel index of the write |
| wr_data | input | 16 | Holdoff value in quanta |
| xoff_active | input | NUM_PRI+1 | Per-channel congestion level, bit 0 is the pause channel |
| xoff_sent | input | NUM_PRI+1 | Per-channel strobe: an XOFF frame was transmitted |
| retx_en | input | NUM_PRI+1 | Per-channel automatic retransmission enable |
| retx_req | output | NUM_PRI+1 | Per-channel one-cycle retransmit request |

## Verification
The hardest case to reach is the power-on value. At 8-cycle quanta an all-ones holdoff takes over half a million cycles, and no read path exists to observe it directly. The bench therefore releases only the power-on reset, selects 2-cycle quanta, and waits out the full 131070-cycle interval on the pause channel. Two other cases need exact timing and are driven directly:
- a reload that coincides with expiry;
- a write or a speed change placed in the middle of a countdown.

Randomised rounds then cover channel, speed code, value (including 0) and enable.

// File: rtl/xoff_holdoff_timer.sv
module xoff_holdoff_timer #(
  parameter int                    NUM_PRI       = 8,
  parameter logic [15:0]           PAUSE_DEFAULT = 16'd1024,
  parameter logic [NUM_PRI*16-1:0] PFC_DEFAULTS  = {NUM_PRI{16'd512}},
  localparam int                   NCH           = NUM_PRI + 1,
  localparam int                   AW            = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           cfg_rst_n,
  input  logic [1:0]     speed_sel,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [15:0]    wr_data,
  input  logic [NCH-1:0] xoff_active,
  input  logic [NCH-1:0] xoff_sent,
  input  logic [NCH-1:0] retx_en,
  output logic [NCH-1:0] retx_req
);

  localparam int CW = 19;

  logic fast_q;
  assign fast_q = (speed_sel == 2'b10);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [15:0]   hold_q;
    logic [15:0]   dflt;
    logic [15:0]   eff;
    logic [CW-1:0] load;
    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          req_q;
    logic          wr_hit;

    if (c == 0) begin : g_pause
      assign dflt = PAUSE_DEFAULT;
    end else begin : g_pfc
      assign dflt = PFC_DEFAULTS[(c-1)*16 +: 16];
    end

    assign wr_hit = wr_en && (wr_addr == AW'(c));
    assign eff    = (hold_q == 16'd0) ? 16'd1 : hold_q;
    assign load   = fast_q ? {2'b00, eff, 1'b0} : {eff, 3'b000};

    always_ff @(posedge clk) begin
      if (!por_n)          hold_q <= 16'hFFFF;
      else if (!cfg_rst_n) hold_q <= dflt;
      else if (wr_hit)     hold_q <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!por_n || !cfg_rst_n) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        req_q   <= 1'b0;
      end else begin
        req_q <= 1'b0;
        if (!xoff_active[c]) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
        end else if (xoff_sent[c]) begin
          cnt_q   <= load;
          armed_q <= 1'b1;
        end else if (armed_q) begin
          if (cnt_q == CW'(1)) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            req_q   <= retx_en[c];
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
      end
    end

    assign retx_req[c] = req_q;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n || !cfg_rst_n)
      req_q |=> !req_q); // R10
    AST_REQ_NEEDS_XOFF: assert property (@(posedge clk) disable iff (!por_n || !cfg_rst_n)
      req_q |-> $past(xoff_active[c])); // R8
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n || !cfg_rst_n)
      req_q |-> $past(retx_en[c])); // R4
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!por_n || !cfg_rst_n)
      (xoff_active[c] && xoff_sent[c]) |=> (cnt_q != '0)); // R5
    AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!por_n || !cfg_rst_n)
      (xoff_active[c] && xoff_sent[c]) |=> !req_q); // R12
  end

endmodule

// File: tb/test_xoff_holdoff_timer.sv
module test_xoff_holdoff_timer;
  localparam int NP  = 8;
  localparam int NCH = NP + 1;
  localparam logic [15:0]      TB_PAUSE = 16'd9;
  localparam logic [NP*16-1:0] TB_PFC   = {16'd17, 16'd16, 16'd15, 16'd14,
                                           16'd13, 16'd12, 16'd11, 16'd10};

  logic           clk = 1'b0;
  logic           por_n = 1'b0, cfg_rst_n = 1'b1;
  logic [1:0]     speed_sel = 2'b10;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_addr = '0;
  logic [15:0]    wr_data = '0;
  logic [NCH-1:0] xoff_active = '0, xoff_sent = '0, retx_en = '1;
  logic [NCH-1:0] retx_req;

  xoff_holdoff_timer #(.NUM_PRI(NP), .PAUSE_DEFAULT(TB_PAUSE), .PFC_DEFAULTS(TB_PFC)) i_xoff_holdoff_timer (
    .clk(clk), .por_n(por_n), .cfg_rst_n(cfg_rst_n), .speed_sel(speed_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xoff_active(xoff_active), .xoff_sent(xoff_sent), .retx_en(retx_en),
    .retx_req(retx_req));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, k = 0;
  int first[NCH];
  int cnt[NCH];
  bit done = 0;

  function automatic int cyc(int v, logic [1:0] sp);
    int e = (v == 0) ? 1 : v;
    return e * ((sp == 2'b10) ? 2 : 8);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      k++;
      for (int ch = 0; ch < NCH; ch++)
        if (retx_req[ch]) begin
          if (first[ch] == 0) first[ch] = k;
          cnt[ch]++;
        end
    end
  endtask

  task automatic clear_mon();
    k = 0;
    for (int ch = 0; ch < NCH; ch++) begin first[ch] = 0; cnt[ch] = 0; end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic send(logic [NCH-1:0] m);
    xoff_sent = m;
    step(1);
    xoff_sent = '0;
    clear_mon();
  endtask

  task automatic idle();
    xoff_active = '0;
    step(2);
    clear_mon();
  endtask

  initial begin
    #(20ns * 195000);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clear_mon();
    repeat (3) @(negedge clk);
    chk(retx_req == '0, "reset R6", int'(retx_req), 0);
    por_n = 1'b1;
    step(1);

    // R6: power-on value 0xFFFF on the pause channel at 2-cycle quanta
    speed_sel = 2'b10; xoff_active = 9'b1;
    send(9'b1);
    step(131075);
    chk(first[0] == 131070, "R6 por holdoff", first[0], 131070);
    idle();

    // R7: configuration-reset defaults at 8-cycle quanta
    cfg_rst_n = 1'b0; step(2); cfg_rst_n = 1'b1; step(1);
    speed_sel = 2'b00; xoff_active = '1;
    send('1);
    step(140);
    chk(first[0] == 72, "R7 pause default", first[0], 72);
    for (int c = 1; c < NCH; c++)
      chk(first[c] == (9 + c) * 8, "R7 class default", first[c], (9 + c) * 8);
    idle();

    // R1/R11: distinct values, write to unused address ignored, all concurrent
    speed_sel = 2'b10;
    for (int c = 0; c < NCH; c++) wr(c, 3 + 2 * c);
    wr(12, 1);
    xoff_active = '1;
    send('1);
    step(50);
    for (int c = 0; c < NCH; c++) begin
      chk(first[c] == (3 + 2 * c) * 2, "R1 R11 per-channel interval", first[c], (3 + 2 * c) * 2);
      chk(cnt[c] == 1, "R10 single pulse", cnt[c], 1);
    end
    idle();

    // R5: value 0 behaves like 1
    speed_sel = 2'b00; wr(2, 0); xoff_active = 9'b100;
    send(9'b100); step(12);
    chk(first[2] == 8, "R5 zero as one", first[2], 8);
    // R10: nothing more without a new send
    step(100);
    chk(cnt[2] == 1, "R10 no repeat", cnt[2], 1);
    idle();

    // R8: deassert mid-count, then reassert without send
    wr(3, 10); xoff_active = 9'b1000;
    send(9'b1000); step(30);
    xoff_active = '0; step(5);
    xoff_active = 9'b1000; step(100);
    chk(cnt[3] == 0, "R8 no request after drop", cnt[3], 0);
    idle();

    // R9: write mid-count, then new value on next reload
    wr(4, 10); xoff_active = 9'b10000;
    send(9'b10000); step(20);
    wr(4, 3);
    step(70);
    chk(first[4] == 80, "R9 running interval kept", first[4], 80);
    send(9'b10000); step(30);
    chk(first[4] == 24, "R9 new value at reload", first[4], 24);
    idle();

    // R12: reload coinciding with expiry
    speed_sel = 2'b10; wr(5, 2); xoff_active = 9'b100000;
    send(9'b100000); step(3);
    xoff_sent = 9'b100000; step(1); xoff_sent = '0;
    chk(cnt[5] == 0, "R12 reload wins", cnt[5], 0);
    clear_mon(); step(8);
    chk(first[5] == 4, "R12 new interval", first[5], 4);
    idle();

    // R13: speed change mid-count does not alter running interval
    speed_sel = 2'b00; wr(6, 5); xoff_active = 9'b1000000;
    send(9'b1000000); step(5);
    speed_sel = 2'b10; step(50);
    chk(first[6] == 40, "R13 speed captured at reload", first[6], 40);
    idle();

    // R4: enable low at launch but high at expiry fires; low at expiry does not
    wr(7, 4); xoff_active = 9'b10000000; retx_en = 9'b101111111;
    send(9'b10000000); step(3);
    retx_en = '1; step(10);
    chk(first[7] == 8, "R4 enable sampled at expiry", first[7], 8);
    send(9'b10000000); step(5);
    retx_en = 9'b101111111; step(10);
    chk(cnt[7] == 0, "R4 disabled at expiry", cnt[7], 0);
    retx_en = '1;
    idle();

    // Random rounds: R2/R3/R4/R5
    for (int it = 0; it < 30; it++) begin
      int ch = $urandom_range(0, NCH - 1);
      int v  = $urandom_range(0, 40);
      logic [1:0] sp = 2'($urandom_range(0, 3));
      bit en = ($urandom_range(0, 3) != 0);
      int e  = cyc(v, sp);
      speed_sel = sp;
      wr(ch, v);
      retx_en = '1; retx_en[ch] = en;
      xoff_active = '0; xoff_active[ch] = 1'b1;
      xoff_sent = '0; xoff_sent[ch] = 1'b1;
      step(1); xoff_sent = '0; clear_mon();
      step(e + 3);
      if (!en) chk(cnt[ch] == 0, "R4 random disabled", cnt[ch], 0);
      else if (sp == 2'b10) chk(first[ch] == e, "R3 random 2-cycle quanta", first[ch], e);
      else chk(first[ch] == e, "R2 random 8-cycle quanta", first[ch], e);
      retx_en = '1;
      idle();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule